// File: doc/BRIEF.md
# Pointer Delta Coordinate Updater

This block keeps a pointer position that lives in memory as two consecutive 16-bit words, horizontal first and vertical second. Each time it is serviced with a strobe, it samples a 4-bit motion code and decodes it into a signed step of -1, 0 or +1 on each axis. If the code describes any motion, it reads both coordinates, adds the steps, and writes both words back through a simple request/ready memory port. If the code describes no motion, the memory is left alone.

A service is launched by `start` together with the code on `motion`. The block raises `done` for one cycle when the service is over. A code with no motion finishes one cycle after the strobe. A moving code finishes after four memory transfers: read X, read Y, write X, write Y. The coordinate pair sits at a base address set by parameter. The arithmetic wraps modulo 2^16 and never saturates.

Top module: `pointer_delta_updater`

## Requirements
- R1: After reset, `done` and `memReq` are both 0 until a strobe is accepted.
- R2: Codes 0 and 9 to 15 mean no motion. After such a strobe, `done` is 1 in the next cycle, and no memory request is made.
- R3: Codes decode to the step pair (dX, dY) as follows: 1=(0,-1), 2=(0,+1), 3=(-1,0), 4=(-1,-1), 5=(-1,+1), 6=(+1,0), 7=(+1,-1), 8=(+1,+1).
- R4: A moving code produces exactly four transfers, in this order: a read of X at `BASE_ADDR`, a read of Y at `BASE_ADDR`+1, a write of the new X at `BASE_ADDR`, and a write of the new Y at `BASE_ADDR`+1. `memWrite`=1 marks a write and 0 a read.
- R5: Coordinate updates are 16-bit two's complement and wrap: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R6: `done` is high for exactly one cycle, in the cycle after the final write is accepted, and `memReq` is 0 while `done` is 1.
- R7: A request holds `memReq`, `memWrite`, `memAddr` and `memWdata` unchanged until the cycle in which `memReady` is 1. That cycle completes the transfer, and in it `memRdata` carries the read data.
- R8: A strobe that arrives while a memory update is in progress is ignored and does not change the update or the stored coordinates.
- R9: A strobe in the cycle where `done` is 1 is accepted and starts the next service at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Service strobe |
| motion | input | 4 | Motion code sampled with the strobe |
| memReq | output | 1 | Memory transfer request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Word address of the transfer |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid when memReady is 1 |
| memReady | input | 1 | Transfer completes in this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one service and the acceptance of the next strobe. The bench raises a new strobe in exactly the cycle where `done` is seen. It then judges the run by the eight transfers that must follow without a gap and by the combined coordinate result. A second same-cycle case is a strobe that arrives while a read is still stalled on `memReady`. That strobe must leave the transfer count at four and the result equal to a single update.

// File: rtl/pdu_pkg.sv
package pdu_pkg;

  localparam logic [1:0] STEP_NEG  = 2'b11;
  localparam logic [1:0] STEP_ZERO = 2'b00;
  localparam logic [1:0] STEP_POS  = 2'b01;

  typedef struct packed {
    logic [1:0] dx;
    logic [1:0] dy;
  } stepT;

  typedef struct packed {
    logic latchCode;
    logic captureX;
    logic captureY;
    logic selY;
  } dpCtrlT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDX, ST_RDY, ST_WRX, ST_WRY, ST_FIN
  } ctlStateT;

  function automatic stepT decodeMotion(input logic [3:0] code);
    stepT s;
    unique case (code)
      4'd1:    s = '{dx: STEP_ZERO, dy: STEP_NEG};
      4'd2:    s = '{dx: STEP_ZERO, dy: STEP_POS};
      4'd3:    s = '{dx: STEP_NEG,  dy: STEP_ZERO};
      4'd4:    s = '{dx: STEP_NEG,  dy: STEP_NEG};
      4'd5:    s = '{dx: STEP_NEG,  dy: STEP_POS};
      4'd6:    s = '{dx: STEP_POS,  dy: STEP_ZERO};
      4'd7:    s = '{dx: STEP_POS,  dy: STEP_NEG};
      4'd8:    s = '{dx: STEP_POS,  dy: STEP_POS};
      default: s = '{dx: STEP_ZERO, dy: STEP_ZERO};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pdu_decode.sv
module pdu_decode
  import pdu_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output stepT              step,
  output logic              hasMotion
);

  logic [3:0] maskedCode;

  generate
    if (CODE_W > 4) begin : g_mask
      assign maskedCode = code[3:0];
    end else begin : g_pad
      assign maskedCode = 4'(code);
    end
  endgenerate

  always_comb begin
    step      = decodeMotion(maskedCode);
    hasMotion = (step.dx != STEP_ZERO) || (step.dy != STEP_ZERO);
  end

  // R3: a decoded step is never -2
  always_comb begin
    a_r3_step_legal: assert (step.dx != 2'b10 && step.dy != 2'b10);
  end

endmodule

// File: rtl/pdu_ctrl.sv
module pdu_ctrl
  import pdu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   hasMotion,
  input  logic   memReady,
  output logic   memReq,
  output logic   memWrite,
  output logic   done,
  output dpCtrlT ctl
);

  ctlStateT state, stateNext;
  logic acceptStart;

  assign acceptStart = start && (state == ST_IDLE || state == ST_FIN);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_FIN: begin
        if (acceptStart) stateNext = hasMotion ? ST_RDX : ST_FIN;
        else             stateNext = ST_IDLE;
      end
      ST_RDX:  if (memReady) stateNext = ST_RDY;
      ST_RDY:  if (memReady) stateNext = ST_WRX;
      ST_WRX:  if (memReady) stateNext = ST_WRY;
      ST_WRY:  if (memReady) stateNext = ST_FIN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    memReq       = (state == ST_RDX) || (state == ST_RDY) ||
                   (state == ST_WRX) || (state == ST_WRY);
    memWrite     = (state == ST_WRX) || (state == ST_WRY);
    done         = (state == ST_FIN);
    ctl.latchCode = acceptStart;
    ctl.captureX  = (state == ST_RDX) && memReady;
    ctl.captureY  = (state == ST_RDY) && memReady;
    ctl.selY      = (state == ST_RDY) || (state == ST_WRY);
  end

  // R2: a still code finishes next cycle without a request
  a_r2_still_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStart && !hasMotion) |=> (done && !memReq));

  // R6: no request while done is shown
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R4: writing starts only right after a completed read
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrite) |-> $past(memReq && !memWrite && memReady));

  // R8: a stalled transfer is not disturbed by a strobe
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && start) |=> memReq);

endmodule

// File: rtl/pdu_datapath.sv
module pdu_datapath
  import pdu_pkg::*;
#(
  parameter int                 DATA_W    = 16,
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctl,
  input  stepT              stepIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int LANES = 2;
  localparam int EXT_W = DATA_W - 2;

  logic [DATA_W-1:0] sumW [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [1:0]        stepQ;
      logic [DATA_W-1:0] coordQ;
      logic              laneCapture;
      logic [1:0]        laneStep;

      assign laneCapture = (g == 0) ? ctl.captureX : ctl.captureY;
      assign laneStep    = (g == 0) ? stepIn.dx : stepIn.dy;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stepQ  <= STEP_ZERO;
          coordQ <= '0;
        end else begin
          if (ctl.latchCode) stepQ  <= laneStep;
          if (laneCapture)   coordQ <= memRdata;
        end
      end

      assign sumW[g] = coordQ + {{EXT_W{stepQ[1]}}, stepQ};
    end
  endgenerate

  assign memAddr  = BASE_ADDR + ADDR_W'(ctl.selY);
  assign memWdata = ctl.selY ? sumW[1] : sumW[0];

  // R4: the X read goes to the base word
  a_r4_x_at_base: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureX |-> (memAddr == BASE_ADDR));

  // R4: the Y read goes to the word after the base
  a_r4_y_after_base: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureY |-> (memAddr == BASE_ADDR + ADDR_W'(1)));

endmodule

// File: rtl/pointer_delta_updater.sv
module pointer_delta_updater
  import pdu_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        motion,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              done
);

  stepT   step;
  logic   hasMotion;
  dpCtrlT ctl;

  pdu_decode #(.CODE_W(4)) u_decode (
    .code      (motion),
    .step      (step),
    .hasMotion (hasMotion)
  );

  pdu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .hasMotion (hasMotion),
    .memReady  (memReady),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .done      (done),
    .ctl       (ctl)
  );

  pdu_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stepIn   (step),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  // R7: a pending request stays unchanged until ready
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWrite) &&
                               $stable(memAddr) && $stable(memWdata)));

  // R6: the completion pulse lasts one cycle unless restarted
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

endmodule

// File: tb/sim_pointer_delta_updater.sv
module sim_pointer_delta_updater;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] BASE       = 16'h0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  motion = 4'd0;
  logic        memReq, memWrite, done;
  logic [15:0] memAddr, memWdata;
  logic [15:0] memRdata = 16'h0;
  logic        memReady = 1'b0;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [15:0] memX = 16'h0, memY = 16'h0;
  logic [15:0] trAddr [16];
  logic        trWr   [16];
  logic [15:0] trData [16];
  int          trCount = 0;
  int          waitCfg = 0;
  int          waitCnt = 0;
  int          cycNum = 0;
  int          lastAcceptCyc = 0;
  int          holdErr = 0;
  bit          pendValid = 0;
  logic [15:0] pendAddr, pendData;
  logic        pendWr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pointer_delta_updater #(.DATA_W(16), .ADDR_W(16), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .motion(motion),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .done(done)
  );

  initial begin
    forever begin
      @(negedge clk);
      cycNum++;
      if (memReq && pendValid &&
          (memAddr !== pendAddr || memWrite !== pendWr ||
           (memWrite && memWdata !== pendData)))
        holdErr++;
      if (memReq && waitCnt >= waitCfg) begin
        memReady = 1'b1;
        waitCnt = 0;
        pendValid = 0;
        lastAcceptCyc = cycNum;
        if (trCount < 16) begin
          trAddr[trCount] = memAddr;
          trWr[trCount]   = memWrite;
        end
        if (memWrite) begin
          if (memAddr == BASE)               memX = memWdata;
          else if (memAddr == BASE + 16'd1)  memY = memWdata;
          if (trCount < 16) trData[trCount] = memWdata;
        end else begin
          memRdata = (memAddr == BASE) ? memX :
                     (memAddr == BASE + 16'd1) ? memY : 16'hDEAD;
          if (trCount < 16) trData[trCount] = memRdata;
        end
        trCount++;
      end else begin
        memReady = 1'b0;
        if (memReq) begin
          waitCnt++;
          pendValid = 1;
          pendAddr = memAddr; pendWr = memWrite; pendData = memWdata;
        end else begin
          pendValid = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int stepOf(input int code, input bit yAxis);
    int dx, dy;
    case (code)
      1: begin dx = 0;  dy = -1; end
      2: begin dx = 0;  dy = 1;  end
      3: begin dx = -1; dy = 0;  end
      4: begin dx = -1; dy = -1; end
      5: begin dx = -1; dy = 1;  end
      6: begin dx = 1;  dy = 0;  end
      7: begin dx = 1;  dy = -1; end
      8: begin dx = 1;  dy = 1;  end
      default: begin dx = 0; dy = 0; end
    endcase
    return yAxis ? dy : dx;
  endfunction

  task automatic strobe(input int code);
    @(negedge clk);
    start = 1'b1; motion = 4'(code);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen, output int doneCyc);
    seen = 0; doneCyc = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1; doneCyc = cycNum; break; end
      @(negedge clk);
    end
  endtask

  task automatic checkTrace(input int base, input logic [15:0] x0,
                            input logic [15:0] y0, input int code, input string tag);
    logic [15:0] nx, ny;
    nx = x0 + 16'(stepOf(code, 0));
    ny = y0 + 16'(stepOf(code, 1));
    check(trAddr[base] == BASE && !trWr[base] && trData[base] == x0, "R4", "read X", int'(trAddr[base]), int'(BASE));
    check(trAddr[base+1] == BASE + 16'd1 && !trWr[base+1] && trData[base+1] == y0, "R4", "read Y", int'(trAddr[base+1]), int'(BASE) + 1);
    check(trAddr[base+2] == BASE && trWr[base+2] && trData[base+2] == nx, tag, "write X", int'(trData[base+2]), int'(nx));
    check(trAddr[base+3] == BASE + 16'd1 && trWr[base+3] && trData[base+3] == ny, tag, "write Y", int'(trData[base+3]), int'(ny));
  endtask

  task automatic runMove(input int code, input logic [15:0] x0, input logic [15:0] y0,
                         input string tag);
    bit seen; int dc;
    memX = x0; memY = y0; trCount = 0;
    strobe(code);
    waitDone(seen, dc);
    check(seen, "R6", "done seen", int'(seen), 1);
    check(dc == lastAcceptCyc + 1, "R6", "done timing", dc, lastAcceptCyc + 1);
    check(trCount == 4, "R4", "transfer count", trCount, 4);
    checkTrace(0, x0, y0, code, tag);
    check(memX == x0 + 16'(stepOf(code, 0)), tag, "stored X", int'(memX), int'(x0 + 16'(stepOf(code, 0))));
    check(memY == y0 + 16'(stepOf(code, 1)), tag, "stored Y", int'(memY), int'(y0 + 16'(stepOf(code, 1))));
    @(negedge clk);
    check(!done, "R6", "pulse width", int'(done), 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !memReq, "R1", "outputs in reset", int'({done, memReq}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !memReq, "R1", "outputs after reset", int'({done, memReq}), 0);
  endtask

  task automatic testTable();
    waitCfg = 0;
    for (int c = 1; c <= 8; c++) runMove(c, 16'd100, 16'd200, "R3");
  endtask

  task automatic testStill();
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 8) continue;
      trCount = 0;
      strobe(c);
      check(done && !memReq && trCount == 0, "R2", "still code", int'({done, memReq}), 2);
      @(negedge clk);
      check(!done && trCount == 0, "R2", "after still", trCount, 0);
    end
  endtask

  task automatic testWrap();
    runMove(8, 16'hFFFF, 16'hFFFF, "R5");
    runMove(4, 16'h0000, 16'h0000, "R5");
  endtask

  task automatic testStall();
    waitCfg = 3; holdErr = 0;
    runMove(5, 16'h1234, 16'h8000, "R7");
    check(holdErr == 0, "R7", "hold violations", holdErr, 0);
    waitCfg = 0;
  endtask

  task automatic testBusy();
    bit seen; int dc;
    waitCfg = 2;
    memX = 16'd50; memY = 16'd60; trCount = 0;
    strobe(6);
    @(negedge clk);
    start = 1'b1; motion = 4'd3;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen, dc);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(trCount == 4, "R8", "transfer count", trCount, 4);
    check(memX == 16'd51 && memY == 16'd60, "R8", "stored X", int'(memX), 51);
    waitCfg = 0;
  endtask

  task automatic testBackToBack();
    bit seen; int dc;
    waitCfg = 0;
    memX = 16'd10; memY = 16'd20; trCount = 0;
    strobe(7);
    waitDone(seen, dc);
    start = 1'b1; motion = 4'd2;
    @(negedge clk);
    start = 1'b0;
    check(memReq && !done, "R9", "restart in done cycle", int'({memReq, done}), 2);
    waitDone(seen, dc);
    check(seen && trCount == 8, "R9", "transfer count", trCount, 8);
    checkTrace(4, 16'd11, 16'd19, 2, "R9");
    check(memX == 16'd11 && memY == 16'd20, "R9", "stored Y", int'(memY), 20);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testTable();
    testStill();
    testWrap();
    testStall();
    testBusy();
    testBackToBack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule